// File: doc/BRIEF.md
# Paravirtual PCI I/O register file

This block is the device-side register file that sits behind the I/O window of a legacy paravirtual PCI device. A host-side register bus reaches it with a byte address, an access width, a write strobe with write data, and a read strobe. Read data is combinational and is valid in the cycle that the read strobe is high. Writes and read side effects take effect at the rising clock edge that ends the access.

The file holds the feature words, the device status byte, and a queue selector. The selector banks a page-frame register and an MSI-X vector for each queue. A write to the notify register produces a pulse that carries the queue index. The block also holds a read-to-clear interrupt status byte and, when MSI-X is on, a configuration-change vector. Any access that falls past the common header goes to a device-specific port with the address rebased to zero. That boundary is at byte 20 when MSI-X is off and at byte 24 when it is on.

Register data is right-aligned on the data buses. A byte register uses bits 7:0 and a 16-bit register uses bits 15:0.

Top module: `pvdev_ioregs`

## Requirements
- R1: After reset the following hold: guest features read 0, device status reads 0, the interrupt status reads 0, `irq_o` is 0, `notify_o` is 0, and both vector registers read 0xFFFF.
- R2: A read at byte 0 returns `host_feat_i`. A write at byte 0 has no effect.
- R3: Byte 4 is a 32-bit guest-feature register. It reads back the last value written to it, and its value also appears on `guest_feat_o`.
- R4: Byte 8 holds a 32-bit page-frame number for each queue, and a read or write at byte 8 reaches only the copy of the selected queue. `ring_addr_o` equals the selected frame number shifted left by 12.
- R5: Byte 12 reads the parameter `QDEPTH` when the selector is below `NUM_Q`, and reads 0 otherwise. When the selector is at or above `NUM_Q`, a write at byte 8 changes no queue and a read at byte 8 returns 0.
- R6: Byte 14 is a 16-bit queue selector that reads back the value written to it.
- R7: A write at byte 16 raises `notify_o` for exactly the next cycle, with `notify_idx_o` equal to bits 15:0 of the written data.
- R8: Byte 19 is the interrupt status. Bit 0 is set by `q_irq_i` and bit 1 (mask 0x2) is set by `cfg_chg_i`. A read returns the value and clears it, and a bit whose set input is high in the same cycle as the clearing read stays set after that read.
- R9: `irq_o` is high while any interrupt status bit is set and `msix_en_i` is low.
- R10: With `msix_en_i` high, byte 20 is a 16-bit config vector and byte 22 is a 16-bit vector for each queue, banked by the selector. The value 0xFFFF means that no vector is assigned.
- R11: An access at or above the device-space base (20 with MSI-X off, 24 with it on) raises `dev_rd_o` or `dev_wr_o` in the same cycle. That access carries `dev_addr_o` equal to the address minus the base, the bus width on `dev_size_o`, and the bus write data, and a read returns `dev_rdata_i`.
- R12: Byte 18 is the device status byte. Writing 0 to it resets the device: guest features and every queue frame number go to 0, the interrupt status goes to 0, and all vectors go to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address within the I/O window |
| bus_size | input | 2 | Access width: 0 byte, 1 half-word, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, combinational |
| host_feat_i | input | 32 | Features the device offers |
| msix_en_i | input | 1 | MSI-X enabled |
| q_irq_i | input | 1 | Queue interrupt event |
| cfg_chg_i | input | 1 | Configuration change event |
| irq_o | output | 1 | Level interrupt |
| notify_o | output | 1 | One-cycle queue notify pulse |
| notify_idx_o | output | 16 | Queue index of the notify |
| ring_addr_o | output | 44 | Ring address of the selected queue |
| guest_feat_o | output | 32 | Accepted guest features |
| dev_status_o | output | 8 | Device status byte |
| dev_wr_o | output | 1 | Device-space write strobe |
| dev_rd_o | output | 1 | Device-space read strobe |
| dev_addr_o | output | 8 | Rebased device-space address |
| dev_size_o | output | 2 | Device-space access width |
| dev_wdata_o | output | 32 | Device-space write data |
| dev_rdata_i | input | 32 | Device-space read data |

## Verification
The assertions check on every cycle that a clearing read with no new event empties the interrupt status, and that an event entering during a clear is kept. They also check that an out-of-range selector leaves every frame number untouched, that a device reset zeroes the frames and restores the vectors, that the interrupt line stays low under MSI-X, and that notify and forwarded strobes arise only from the matching accesses. Only the bench scenarios can show the banking itself. That covers values that survive a change of selector and come back after it, the boundary that moves with MSI-X, the rebased device addresses, and the read values after a device reset.

// File: rtl/pvdev_pkg.sv
// Shared constants for the paravirtual PCI I/O register file.
// Assumes: byte-addressed window, right-aligned register data.
package pvdev_pkg;
    // Register byte offsets (fixed by the host driver ABI)
    localparam logic [7:0] OFF_HOST_FEAT  = 8'd0;
    localparam logic [7:0] OFF_GUEST_FEAT = 8'd4;
    localparam logic [7:0] OFF_QFRAME     = 8'd8;
    localparam logic [7:0] OFF_QDEPTH     = 8'd12;
    localparam logic [7:0] OFF_QSEL       = 8'd14;
    localparam logic [7:0] OFF_QKICK      = 8'd16;
    localparam logic [7:0] OFF_STATUS     = 8'd18;
    localparam logic [7:0] OFF_INTSTAT    = 8'd19;
    localparam logic [7:0] OFF_VEC_CFG    = 8'd20;
    localparam logic [7:0] OFF_VEC_QUEUE  = 8'd22;
    // Start of device-specific space without / with MSI-X
    localparam logic [7:0] DEVSPACE_PLAIN = 8'd20;
    localparam logic [7:0] DEVSPACE_MSIX  = 8'd24;

    localparam int         FRAME_SHIFT    = 12;
    localparam int         VEC_W          = 16;
    localparam logic [VEC_W-1:0] VEC_NONE = 16'hFFFF;

    localparam int INT_QUEUE_BIT = 0;
    localparam int INT_CFG_BIT   = 1;
endpackage

// File: rtl/pvdev_intstat.sv
// Read-to-clear interrupt status byte.
// Bit 0 records queue events, bit 1 records config changes. A clearing
// read and a set event in the same cycle leave the new event set.
// Assumes: rd_clr is high for exactly the cycle of the status read.
module pvdev_intstat
    import pvdev_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_clr,
    input  logic       dev_reset,
    input  logic       q_evt,
    input  logic       cfg_evt,
    output logic [7:0] stat
);
    logic [7:0] set_bits;

    // Gather the set events into their bit positions
    always_comb begin
        set_bits                = '0;
        set_bits[INT_QUEUE_BIT] = q_evt;
        set_bits[INT_CFG_BIT]   = cfg_evt;
    end

    // Clear on read or device reset, then merge in new events
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= ((rd_clr || dev_reset) ? 8'h00 : stat) | set_bits;
    end

    // R8: a clearing read with no new event empties the byte
    assert_isr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !q_evt && !cfg_evt) |=> (stat == 8'h00));
    // R8: a config event survives a simultaneous clear
    assert_isr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_evt |=> stat[INT_CFG_BIT]);
endmodule

// File: rtl/pvdev_queue_bank.sv
// Per-queue banked state: page-frame number and MSI-X vector.
// The selector picks one bank for read and write. Selectors at or
// above NUM_Q reach no bank and read back as zero / no-vector.
// Assumes: NUM_Q >= 2, SEL_W wide enough to name every queue.
module pvdev_queue_bank
    import pvdev_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int FRAME_W = 32,
    parameter int SEL_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic               dev_reset,
    input  logic               frame_we,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               vec_we,
    input  logic [VEC_W-1:0]   vec_wdata,
    output logic               sel_valid,
    output logic [FRAME_W-1:0] frame_rd,
    output logic [VEC_W-1:0]   vec_rd
);
    localparam int IDX_W = $clog2(NUM_Q);

    logic [IDX_W-1:0]           idx;
    logic [FRAME_W-1:0]         frame_q [NUM_Q];
    logic [VEC_W-1:0]           vec_q   [NUM_Q];
    logic [NUM_Q*FRAME_W-1:0]   frame_flat;

    assign sel_valid = (sel < SEL_W'(NUM_Q));
    assign idx       = sel[IDX_W-1:0];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_bank
        // Hold this queue's frame number and vector
        always_ff @(posedge clk) begin
            if (!rst_n || dev_reset) begin
                frame_q[q] <= '0;
                vec_q[q]   <= VEC_NONE;
            end else if (sel_valid && idx == IDX_W'(q)) begin
                if (frame_we) frame_q[q] <= frame_wdata;
                if (vec_we)   vec_q[q]   <= vec_wdata;
            end
        end
        assign frame_flat[q*FRAME_W +: FRAME_W] = frame_q[q];
    end

    // Read mux for the selected bank
    always_comb begin
        frame_rd = '0;
        vec_rd   = VEC_NONE;
        for (int q = 0; q < NUM_Q; q++) begin
            if (sel_valid && idx == IDX_W'(q)) begin
                frame_rd = frame_q[q];
                vec_rd   = vec_q[q];
            end
        end
    end

    // R5: out-of-range selector leaves every frame unchanged
    assert_oob_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_we && !sel_valid && !dev_reset) |=> $stable(frame_flat));
    // R12: device reset zeroes every frame number
    assert_reset_frames_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (frame_flat == '0));
endmodule

// File: rtl/pvdev_ioregs.sv
// I/O register file of a legacy paravirtual PCI device.
// Decodes the common header and keeps features, status and selector.
// Banks per-queue state through pvdev_queue_bank and keeps the
// interrupt status in pvdev_intstat. Accesses at or above the
// device-space base go out on the dev_* port with a rebased address.
// Assumes: aligned accesses, data right-aligned, one strobe at a time.
module pvdev_ioregs
    import pvdev_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int NUM_Q   = 4,
    parameter int QDEPTH  = 256,
    parameter int FRAME_W = 32,
    parameter int SEL_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [1:0]                   bus_size,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [DATA_W-1:0]            host_feat_i,
    input  logic                         msix_en_i,
    input  logic                         q_irq_i,
    input  logic                         cfg_chg_i,
    output logic                         irq_o,
    output logic                         notify_o,
    output logic [SEL_W-1:0]             notify_idx_o,
    output logic [FRAME_W+FRAME_SHIFT-1:0] ring_addr_o,
    output logic [DATA_W-1:0]            guest_feat_o,
    output logic [7:0]                   dev_status_o,
    output logic                         dev_wr_o,
    output logic                         dev_rd_o,
    output logic [ADDR_W-1:0]            dev_addr_o,
    output logic [1:0]                   dev_size_o,
    output logic [DATA_W-1:0]            dev_wdata_o,
    input  logic [DATA_W-1:0]            dev_rdata_i
);
    localparam logic [ADDR_W-1:0] A_HOST  = ADDR_W'(OFF_HOST_FEAT);
    localparam logic [ADDR_W-1:0] A_GUEST = ADDR_W'(OFF_GUEST_FEAT);
    localparam logic [ADDR_W-1:0] A_FRAME = ADDR_W'(OFF_QFRAME);
    localparam logic [ADDR_W-1:0] A_DEPTH = ADDR_W'(OFF_QDEPTH);
    localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(OFF_QSEL);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFF_QKICK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_INT   = ADDR_W'(OFF_INTSTAT);
    localparam logic [ADDR_W-1:0] A_VCFG  = ADDR_W'(OFF_VEC_CFG);
    localparam logic [ADDR_W-1:0] A_VQ    = ADDR_W'(OFF_VEC_QUEUE);
    localparam logic [ADDR_W-1:0] B_PLAIN = ADDR_W'(DEVSPACE_PLAIN);
    localparam logic [ADDR_W-1:0] B_MSIX  = ADDR_W'(DEVSPACE_MSIX);

    logic [DATA_W-1:0]  guest_feat;
    logic [7:0]         status;
    logic [SEL_W-1:0]   qsel;
    logic [VEC_W-1:0]   cfg_vec;
    logic [7:0]         int_stat;
    logic [ADDR_W-1:0]  dev_base;
    logic               in_dev;
    logic               hdr_wr;
    logic               dev_reset;
    logic               sel_valid;
    logic [FRAME_W-1:0] frame_rd;
    logic [VEC_W-1:0]   qvec_rd;

    // Locate the device-space boundary and classify the access
    assign dev_base  = msix_en_i ? B_MSIX : B_PLAIN;
    assign in_dev    = (bus_addr >= dev_base);
    assign hdr_wr    = bus_wr && !in_dev;
    assign dev_reset = hdr_wr && (bus_addr == A_STAT) && (bus_wdata[7:0] == 8'h00);

    // Header registers owned directly by this level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guest_feat <= '0;
            status     <= '0;
            qsel       <= '0;
            cfg_vec    <= VEC_NONE;
        end else begin
            if (hdr_wr && bus_addr == A_GUEST) guest_feat <= bus_wdata;
            if (hdr_wr && bus_addr == A_SEL)   qsel       <= bus_wdata[SEL_W-1:0];
            if (hdr_wr && bus_addr == A_STAT)  status     <= bus_wdata[7:0];
            if (hdr_wr && msix_en_i && bus_addr == A_VCFG)
                cfg_vec <= bus_wdata[VEC_W-1:0];
            if (dev_reset) begin
                guest_feat <= '0;
                cfg_vec    <= VEC_NONE;
            end
        end
    end

    // One-cycle notify pulse carrying the written queue index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_o     <= 1'b0;
            notify_idx_o <= '0;
        end else begin
            notify_o <= hdr_wr && (bus_addr == A_KICK);
            if (hdr_wr && bus_addr == A_KICK) notify_idx_o <= bus_wdata[SEL_W-1:0];
        end
    end

    pvdev_queue_bank #(
        .NUM_Q   (NUM_Q),
        .FRAME_W (FRAME_W),
        .SEL_W   (SEL_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (qsel),
        .dev_reset   (dev_reset),
        .frame_we    (hdr_wr && bus_addr == A_FRAME),
        .frame_wdata (bus_wdata[FRAME_W-1:0]),
        .vec_we      (hdr_wr && msix_en_i && bus_addr == A_VQ),
        .vec_wdata   (bus_wdata[VEC_W-1:0]),
        .sel_valid   (sel_valid),
        .frame_rd    (frame_rd),
        .vec_rd      (qvec_rd)
    );

    pvdev_intstat u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_clr    (bus_rd && !in_dev && bus_addr == A_INT),
        .dev_reset (dev_reset),
        .q_evt     (q_irq_i),
        .cfg_evt   (cfg_chg_i),
        .stat      (int_stat)
    );

    // Read-data mux: device space first, then the header registers
    always_comb begin
        bus_rdata = '0;
        if (in_dev) begin
            bus_rdata = dev_rdata_i;
        end else begin
            case (bus_addr)
                A_HOST:  bus_rdata = host_feat_i;
                A_GUEST: bus_rdata = guest_feat;
                A_FRAME: bus_rdata = DATA_W'(frame_rd);
                A_DEPTH: bus_rdata = sel_valid ? DATA_W'(QDEPTH) : '0;
                A_SEL:   bus_rdata = DATA_W'(qsel);
                A_STAT:  bus_rdata = DATA_W'(status);
                A_INT:   bus_rdata = DATA_W'(int_stat);
                A_VCFG:  bus_rdata = DATA_W'(cfg_vec);
                A_VQ:    bus_rdata = DATA_W'(qvec_rd);
                default: bus_rdata = '0;
            endcase
        end
    end

    // Device-space forwarding and remaining outputs
    assign dev_wr_o     = bus_wr && in_dev;
    assign dev_rd_o     = bus_rd && in_dev;
    assign dev_addr_o   = bus_addr - dev_base;
    assign dev_size_o   = bus_size;
    assign dev_wdata_o  = bus_wdata;
    assign irq_o        = (|int_stat) && !msix_en_i;
    assign ring_addr_o  = {frame_rd, {FRAME_SHIFT{1'b0}}};
    assign guest_feat_o = guest_feat;
    assign dev_status_o = status;

    // R7: a notify pulse only follows a header write
    assert_notify_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        notify_o |-> $past(bus_wr));
    // R9: no level interrupt while MSI-X is on
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msix_en_i |-> !irq_o);
    // R12: device reset restores the config vector
    assert_vec_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (cfg_vec == VEC_NONE));
    // R11: forwarded reads never hit the common header
    assert_fwd_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_o |-> (bus_addr >= B_PLAIN));
endmodule

// File: tb/tb_pvdev_ioregs.sv
`timescale 1ns/1ps
module tb_pvdev_ioregs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] host_feat_i = 32'hA5A5_0F0F;
    logic        msix_en_i = 1'b0, q_irq_i = 1'b0, cfg_chg_i = 1'b0;
    logic        irq_o, notify_o;
    logic [15:0] notify_idx_o;
    logic [43:0] ring_addr_o;
    logic [31:0] guest_feat_o;
    logic [7:0]  dev_status_o;
    logic        dev_wr_o, dev_rd_o;
    logic [7:0]  dev_addr_o;
    logic [1:0]  dev_size_o;
    logic [31:0] dev_wdata_o;
    logic [31:0] dev_rdata_i = 32'hC0DE_0042;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pvdev_ioregs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_feat_i(host_feat_i), .msix_en_i(msix_en_i), .q_irq_i(q_irq_i),
        .cfg_chg_i(cfg_chg_i), .irq_o(irq_o), .notify_o(notify_o),
        .notify_idx_o(notify_idx_o), .ring_addr_o(ring_addr_o),
        .guest_feat_o(guest_feat_o), .dev_status_o(dev_status_o),
        .dev_wr_o(dev_wr_o), .dev_rd_o(dev_rd_o), .dev_addr_o(dev_addr_o),
        .dev_size_o(dev_size_o), .dev_wdata_o(dev_wdata_o), .dev_rdata_i(dev_rdata_i)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } step_t;

    localparam int NSTEP = 18;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 8'd0,  32'h0,        32'hA5A5_0F0F}, // R2 host read
        '{1'b1, 8'd0,  32'h0,        32'h0},         // R2 write ignored
        '{1'b0, 8'd0,  32'h0,        32'hA5A5_0F0F}, // R2 unchanged
        '{1'b1, 8'd4,  32'hDEAD_BEEF,32'h0},         // R3
        '{1'b0, 8'd4,  32'h0,        32'hDEAD_BEEF}, // R3
        '{1'b1, 8'd14, 32'd1,        32'h0},         // R6 select queue 1
        '{1'b0, 8'd14, 32'h0,        32'd1},         // R6
        '{1'b1, 8'd8,  32'h0001_2345,32'h0},         // R4
        '{1'b0, 8'd8,  32'h0,        32'h0001_2345}, // R4
        '{1'b1, 8'd14, 32'd0,        32'h0},         // R4 switch to queue 0
        '{1'b0, 8'd8,  32'h0,        32'h0},         // R4 bank 0 untouched
        '{1'b0, 8'd12, 32'h0,        32'd256},       // R5 valid depth
        '{1'b1, 8'd14, 32'd7,        32'h0},         // R5 out of range
        '{1'b0, 8'd12, 32'h0,        32'h0},         // R5 depth zero
        '{1'b1, 8'd8,  32'h0000_FFFF,32'h0},         // R5 ignored write
        '{1'b0, 8'd8,  32'h0,        32'h0},         // R5 reads zero
        '{1'b1, 8'd14, 32'd1,        32'h0},         // R5 back to queue 1
        '{1'b0, 8'd8,  32'h0,        32'h0001_2345}  // R5 queue 1 intact
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_rd(8'd4, v);  check("R1 guest", v, 0);
        do_rd(8'd18, v); check("R1 status", v, 0);
        do_rd(8'd19, v); check("R1 intstat", v, 0);
        check("R1 irq", irq_o, 0);
        check("R1 notify", notify_o, 0);
        msix_en_i = 1'b1;
        do_rd(8'd20, v); check("R1 cfg vec", v, 32'hFFFF);
        do_rd(8'd22, v); check("R1 queue vec", v, 32'hFFFF);
        msix_en_i = 1'b0;

        // Table walk
        for (int i = 0; i < NSTEP; i++) begin
            if (STEPS[i].wr) do_wr(STEPS[i].addr, STEPS[i].data);
            else begin
                do_rd(STEPS[i].addr, v);
                check($sformatf("table step %0d", i), v, STEPS[i].exp);
            end
        end
        check("R3 guest_feat_o", guest_feat_o, 32'hDEAD_BEEF);
        #1 check("R4 ring address", ring_addr_o, 44'h0001_2345_000);

        // R7 notify pulse
        do_wr(8'd16, 32'd3);
        #1 check("R7 notify high", notify_o, 1);
        check("R7 notify index", notify_idx_o, 16'd3);
        @(negedge clk); #1 check("R7 notify one cycle", notify_o, 0);

        // R8/R9 interrupt status
        @(negedge clk); q_irq_i = 1'b1;
        @(negedge clk); q_irq_i = 1'b0;
        #1 check("R9 irq level", irq_o, 1);
        @(negedge clk);
        bus_addr = 8'd19; bus_rd = 1'b1; cfg_chg_i = 1'b1;
        #1 check("R8 read value", bus_rdata, 32'h1);
        @(negedge clk); bus_rd = 1'b0; cfg_chg_i = 1'b0;
        do_rd(8'd19, v); check("R8 event kept over clear", v, 32'h2);
        do_rd(8'd19, v); check("R8 cleared", v, 32'h0);
        #1 check("R9 irq low", irq_o, 0);
        @(negedge clk); q_irq_i = 1'b1; msix_en_i = 1'b1;
        @(negedge clk); q_irq_i = 1'b0;
        #1 check("R9 irq gated by msix", irq_o, 0);

        // R10 vectors (msix on, queue 1 selected)
        do_wr(8'd20, 32'd5);
        do_rd(8'd20, v); check("R10 cfg vec", v, 32'd5);
        do_wr(8'd22, 32'd9);
        do_wr(8'd14, 32'd0);
        do_rd(8'd22, v); check("R10 queue0 vec", v, 32'hFFFF);
        do_wr(8'd14, 32'd1);
        do_rd(8'd22, v); check("R10 queue1 vec", v, 32'd9);

        // R11 forwarding with msix on
        @(negedge clk); bus_addr = 8'd24; bus_rd = 1'b1;
        #1 check("R11 dev rd", dev_rd_o, 1);
        check("R11 dev addr msix", dev_addr_o, 8'd0);
        check("R11 dev rdata", bus_rdata, 32'hC0DE_0042);
        @(negedge clk); bus_rd = 1'b0;
        bus_addr = 8'd22; bus_rd = 1'b1; #1 check("R11 vector not forwarded", dev_rd_o, 0);
        @(negedge clk); bus_rd = 1'b0;
        bus_addr = 8'd26; bus_wr = 1'b1; bus_wdata = 32'h77; bus_size = 2'd1;
        #1 check("R11 dev wr", dev_wr_o, 1);
        check("R11 dev wr addr", dev_addr_o, 8'd2);
        check("R11 dev size", dev_size_o, 2'd1);
        check("R11 dev wdata", dev_wdata_o, 32'h77);
        @(negedge clk); bus_wr = 1'b0; bus_size = 2'd2;
        // forwarding with msix off
        msix_en_i = 1'b0;
        bus_addr = 8'd20; bus_rd = 1'b1;
        #1 check("R11 dev rd plain", dev_rd_o, 1);
        check("R11 dev addr plain", dev_addr_o, 8'd0);
        @(negedge clk); bus_rd = 1'b0;

        // R12 device status and device reset
        do_wr(8'd18, 32'h0F);
        do_rd(8'd18, v); check("R12 status", v, 32'h0F);
        check("R12 status port", dev_status_o, 8'h0F);
        do_wr(8'd18, 32'h00);
        do_rd(8'd4, v);  check("R12 guest cleared", v, 0);
        do_rd(8'd8, v);  check("R12 frame cleared", v, 0);
        do_rd(8'd19, v); check("R12 intstat cleared", v, 0);
        msix_en_i = 1'b1;
        do_rd(8'd20, v); check("R12 cfg vec restored", v, 32'hFFFF);
        do_rd(8'd22, v); check("R12 queue vec restored", v, 32'hFFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule